// File: doc/BRIEF.md
# ADC Conversion Sequencer with Injection

This block is the digital control for an analog-to-digital converter. Software starts standard work with a start strobe, a mode select and a channel select. A capture/compare channel can ask for one extra conversion at any time, called an injection. The converter itself is outside the block. It is reached through a handshake: the block pulses a start with a channel number, and some cycles later the converter answers with a one-cycle done pulse and the result.

Standard work runs in one of these modes:
- a single conversion of one channel;
- an auto scan from the selected channel down to channel 0;
- continuous repetition of either of the above until software clears the start bit.

Injected conversions take priority. Each one has its own result register and its own end flag. The block keeps the visible request flag apart from the internal latch that actually drives the injection.

A software start that arrives while an injection is running never aborts it and never stalls the sequencer. This holds even when the start lands in the final cycles of the injection. The start is held. The standard conversion is issued in the cycle after the injected result has been stored.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, every flag and both result registers read 0, `std_busy` is 0 and `conv_start` stays low.
- R2: With `mode_sel`=00 (bit 0 = scan, bit 1 = continuous), a `start_set` pulse causes exactly one conversion. It is issued in the next cycle on `chan_sel`. Its result is written to `std_result`, `eoc_irq` is set and `std_busy` drops.
- R3: With `mode_sel[0]`=1, the channels are converted in descending order from the selected channel down to 0. `std_busy` drops after channel 0 completes.
- R4: With `mode_sel[1]`=1, the sequence restarts at the selected channel after each pass. After a `start_clr` pulse, the pass in progress is finished and then `std_busy` clears.
- R5: A `start_set` pulse while `std_busy` is 1 is ignored. The running sequence keeps its channel and mode.
- R6: An `inj_req` pulse sets both `inj_flag` and `cc_irq` in the following cycle.
- R7: A finished injected conversion writes `inj_result`, sets `eoi_irq` and clears `inj_flag`. It leaves `std_result` unchanged.
- R8: When the converter is idle and both kinds of work are pending, the injection is issued first. `conv_start` never pulses while a conversion is outstanding.
- R9: A `start_set` pulse during an injection, including one in the final two cycles before the injected result is stored, does not abort the injection. The injected result is stored and `eoi_irq` is set. The standard conversion starts in the cycle after storage, and later injection requests are still served.
- R10: Clearing `inj_flag` with `clr_injreq` does not cancel an injection that has already been accepted.
- R11: `eoc_irq`, `eoi_irq` and `cc_irq` stay set until their clear strobe is pulsed. A set and a clear in the same cycle leave the flag at 1.
- R12: `std_busy` stays 1 from an accepted start, including one held behind an injection, until the last conversion of a non-continuous sequence finishes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_set | input | 1 | Software start strobe |
| start_clr | input | 1 | Software start-bit clear strobe (ends continuous mode) |
| mode_sel | input | 2 | Bit 0 scan, bit 1 continuous |
| chan_sel | input | CH_W | Standard channel, top of a scan |
| inj_req | input | 1 | Injection request from the capture/compare channel |
| inj_chan | input | CH_W | Channel for the injection |
| clr_eoc | input | 1 | Clears `eoc_irq` |
| clr_eoi | input | 1 | Clears `eoi_irq` |
| clr_ccir | input | 1 | Clears `cc_irq` |
| clr_injreq | input | 1 | Clears the visible `inj_flag` |
| conv_done | input | 1 | Converter end pulse |
| conv_result | input | RES_W | Converter result, valid with `conv_done` |
| conv_start | output | 1 | Converter start pulse |
| conv_chan | output | CH_W | Channel for the converter |
| std_result | output | RES_W | Last standard result |
| inj_result | output | RES_W | Last injected result |
| std_busy | output | 1 | Standard work active |
| inj_flag | output | 1 | Visible injection-request flag |
| eoc_irq | output | 1 | End-of-conversion interrupt flag |
| eoi_irq | output | 1 | End-of-injection interrupt flag |
| cc_irq | output | 1 | Capture/compare channel interrupt flag |

## Verification
The assertions rely on the converter following its handshake:
- it gives exactly one `conv_done` pulse for each `conv_start`;
- that pulse comes at least one cycle after the start;
- it never pulses `conv_done` while idle.

They also take every strobe to be a single-cycle pulse. The bench's converter model answers only an accepted start, with a configurable latency of one or more cycles. All stimulus is driven as one-cycle pulses on the falling edge. The randomised part draws non-continuous modes, short scans and injection offsets, so every run returns to idle.

// File: rtl/adc_seq_pkg.sv
// Shared types for the ADC conversion sequencer.
// Assumes: nothing beyond the standard language.
package adc_seq_pkg;
    // What the converter is doing for the sequencer right now
    typedef enum logic [1:0] {
        ACT_IDLE = 2'd0,
        ACT_STD  = 2'd1,
        ACT_INJ  = 2'd2
    } act_e;

    // Bit positions inside the mode select
    localparam int MODE_SCAN_BIT = 0;
    localparam int MODE_CONT_BIT = 1;
endpackage

// File: rtl/adc_sticky_flag.sv
// Sticky interrupt/request flag: a set pulse raises it, a clear pulse
// lowers it, and a set wins when both arrive in the same cycle.
// Assumes: set_i and clr_i are synchronous to clk.
module adc_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;

    // Flag register with set priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/adc_std_seq.sv
// Standard conversion sequencer: holds the run state, the latched mode
// and the channel to convert next. It steps the channel down on each
// finished standard conversion and restarts or stops at the end of a pass.
// Assumes: fin_i pulses once per finished standard conversion and only
// while run_o is 1.
module adc_std_seq
    import adc_seq_pkg::*;
#(
    parameter int CH_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_set,
    input  logic            start_clr,
    input  logic [1:0]      mode_sel,
    input  logic [CH_W-1:0] chan_sel,
    input  logic            fin_i,
    output logic            run_o,
    output logic [CH_W-1:0] chan_o
);
    logic            run_q;
    logic            stop_q;
    logic            scan_q;
    logic            cont_q;
    logic [CH_W-1:0] top_q;
    logic [CH_W-1:0] cur_q;
    logic            pass_end;
    logic            restart;
    logic            seq_done;
    logic            accept;

    // End-of-pass decode and start acceptance
    always_comb begin
        pass_end = !scan_q || (cur_q == '0);
        restart  = cont_q && !stop_q && !start_clr;
        seq_done = fin_i && pass_end && !restart;
        accept   = start_set && (!run_q || seq_done);
    end

    // Run, stop, mode and channel registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            stop_q <= 1'b0;
            scan_q <= 1'b0;
            cont_q <= 1'b0;
            top_q  <= '0;
            cur_q  <= '0;
        end else begin
            if (fin_i) begin
                if (!pass_end) begin
                    cur_q <= cur_q - CH_W'(1);
                end else if (restart) begin
                    cur_q <= top_q;
                end else begin
                    run_q <= 1'b0;
                end
            end
            if (start_clr) begin
                stop_q <= 1'b1;
            end
            if (accept) begin
                run_q  <= 1'b1;
                stop_q <= 1'b0;
                scan_q <= mode_sel[MODE_SCAN_BIT];
                cont_q <= mode_sel[MODE_CONT_BIT];
                top_q  <= chan_sel;
                cur_q  <= chan_sel;
            end
        end
    end

    assign run_o  = run_q;
    assign chan_o = cur_q;
endmodule

// File: rtl/adc_inj_ctl.sv
// Injection control: an internal pending latch that drives the sequencing,
// the software-visible request flag (clearing it does not touch the latch),
// and the dedicated injected result register.
// Assumes: issue_i is high only while pend_o is high; fin_i pulses once per
// finished injected conversion.
module adc_inj_ctl #(
    parameter int CH_W  = 4,
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inj_req,
    input  logic [CH_W-1:0]  inj_chan,
    input  logic             issue_i,
    input  logic             fin_i,
    input  logic [RES_W-1:0] conv_result,
    input  logic             clr_flag,
    output logic             pend_o,
    output logic [CH_W-1:0]  chan_o,
    output logic             flag_o,
    output logic [RES_W-1:0] result_o
);
    logic             pend_q;
    logic [CH_W-1:0]  chan_q;
    logic [RES_W-1:0] result_q;

    // Pending latch and its channel; a new request wins over the issue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            chan_q <= '0;
        end else if (inj_req) begin
            pend_q <= 1'b1;
            chan_q <= inj_chan;
        end else if (issue_i) begin
            pend_q <= 1'b0;
        end
    end

    // Injected result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (fin_i) begin
            result_q <= conv_result;
        end
    end

    // Visible request flag, dropped by software or by completion
    adc_sticky_flag u_vis_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (inj_req),
        .clr_i  (clr_flag | fin_i),
        .flag_o (flag_o)
    );

    assign pend_o   = pend_q;
    assign chan_o   = chan_q;
    assign result_o = result_q;
endmodule

// File: rtl/adc_seq_ctrl.sv
// ADC conversion sequencer top: arbitrates the converter between injected
// and standard work (injection first), runs the handshake, holds the
// standard result and the interrupt flags.
// Assumes: the converter answers each conv_start with exactly one
// conv_done, at least one cycle later, and never pulses conv_done while idle.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter  int NUM_CH = 16,
    parameter  int RES_W  = 10,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_set,
    input  logic             start_clr,
    input  logic [1:0]       mode_sel,
    input  logic [CH_W-1:0]  chan_sel,
    input  logic             inj_req,
    input  logic [CH_W-1:0]  inj_chan,
    input  logic             clr_eoc,
    input  logic             clr_eoi,
    input  logic             clr_ccir,
    input  logic             clr_injreq,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_result,
    output logic             conv_start,
    output logic [CH_W-1:0]  conv_chan,
    output logic [RES_W-1:0] std_result,
    output logic [RES_W-1:0] inj_result,
    output logic             std_busy,
    output logic             inj_flag,
    output logic             eoc_irq,
    output logic             eoi_irq,
    output logic             cc_irq
);
    localparam int NFLAG   = 3;
    localparam int F_EOC   = 0;
    localparam int F_EOI   = 1;
    localparam int F_CC    = 2;

    act_e             act_q;
    logic             std_run;
    logic [CH_W-1:0]  std_chan;
    logic             inj_pend;
    logic [CH_W-1:0]  inj_ch;
    logic             conv_idle;
    logic             issue_inj;
    logic             issue_std;
    logic             std_fin;
    logic             inj_fin;
    logic [RES_W-1:0] std_res_q;
    logic [NFLAG-1:0] fl_set;
    logic [NFLAG-1:0] fl_clr;
    logic [NFLAG-1:0] fl_q;

    // Arbitration: injection before standard when the converter is free
    always_comb begin
        conv_idle = (act_q == ACT_IDLE);
        issue_inj = conv_idle && inj_pend;
        issue_std = conv_idle && !inj_pend && std_run;
        std_fin   = conv_done && (act_q == ACT_STD);
        inj_fin   = conv_done && (act_q == ACT_INJ);
    end

    // Converter ownership state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= ACT_IDLE;
        end else if (issue_inj) begin
            act_q <= ACT_INJ;
        end else if (issue_std) begin
            act_q <= ACT_STD;
        end else if (conv_done && !conv_idle) begin
            act_q <= ACT_IDLE;
        end
    end

    // Standard result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            std_res_q <= '0;
        end else if (std_fin) begin
            std_res_q <= conv_result;
        end
    end

    adc_std_seq #(
        .CH_W (CH_W)
    ) u_std (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_set (start_set),
        .start_clr (start_clr),
        .mode_sel  (mode_sel),
        .chan_sel  (chan_sel),
        .fin_i     (std_fin),
        .run_o     (std_run),
        .chan_o    (std_chan)
    );

    adc_inj_ctl #(
        .CH_W  (CH_W),
        .RES_W (RES_W)
    ) u_inj (
        .clk         (clk),
        .rst_n       (rst_n),
        .inj_req     (inj_req),
        .inj_chan    (inj_chan),
        .issue_i     (issue_inj),
        .fin_i       (inj_fin),
        .conv_result (conv_result),
        .clr_flag    (clr_injreq),
        .pend_o      (inj_pend),
        .chan_o      (inj_ch),
        .flag_o      (inj_flag),
        .result_o    (inj_result)
    );

    // Interrupt flag bank: set and clear sources per flag
    always_comb begin
        fl_set        = '0;
        fl_clr        = '0;
        fl_set[F_EOC] = std_fin;
        fl_clr[F_EOC] = clr_eoc;
        fl_set[F_EOI] = inj_fin;
        fl_clr[F_EOI] = clr_eoi;
        fl_set[F_CC]  = inj_req;
        fl_clr[F_CC]  = clr_ccir;
    end

    for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
        adc_sticky_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (fl_set[gi]),
            .clr_i  (fl_clr[gi]),
            .flag_o (fl_q[gi])
        );
    end

    assign conv_start = issue_inj | issue_std;
    assign conv_chan  = inj_pend ? inj_ch : std_chan;
    assign std_result = std_res_q;
    assign std_busy   = std_run;
    assign eoc_irq    = fl_q[F_EOC];
    assign eoi_irq    = fl_q[F_EOI];
    assign cc_irq     = fl_q[F_CC];
endmodule

// File: rtl/adc_seq_chk.sv
// Protocol and flag checker for the ADC conversion sequencer, bound to the
// top. Tracks converter occupancy from the handshake itself.
// Assumes: one conv_done per conv_start, never while idle.
module adc_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start_set,
    input logic inj_req,
    input logic clr_eoc,
    input logic clr_eoi,
    input logic conv_start,
    input logic conv_done,
    input logic std_busy,
    input logic inj_flag,
    input logic eoc_irq,
    input logic eoi_irq,
    input logic cc_irq
);
    logic out_q;

    // Outstanding-conversion tracker built from the port handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else if (conv_start) begin
            out_q <= 1'b1;
        end else if (conv_done) begin
            out_q <= 1'b0;
        end
    end

    assert_single_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !out_q);

    assert_inj_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        inj_req |=> (cc_irq && inj_flag));

    assert_eoi_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_irq && !clr_eoi) |=> eoi_irq);

    assert_eoc_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc_irq && !clr_eoc) |=> eoc_irq);

    assert_busy_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (std_busy && !conv_done) |=> std_busy);

    assert_start_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        start_set |=> std_busy);
endmodule

bind adc_seq_ctrl adc_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_set  (start_set),
    .inj_req    (inj_req),
    .clr_eoc    (clr_eoc),
    .clr_eoi    (clr_eoi),
    .conv_start (conv_start),
    .conv_done  (conv_done),
    .std_busy   (std_busy),
    .inj_flag   (inj_flag),
    .eoc_irq    (eoc_irq),
    .eoi_irq    (eoi_irq),
    .cc_irq     (cc_irq)
);

// File: tb/sim_adc_seq_ctrl.sv
// Bench for adc_seq_ctrl: converter model, directed corner cases and a
// seeded random phase, checked against bench-computed expectations.
module sim_adc_seq_ctrl;
    localparam int NUM_CH = 16;
    localparam int CH_W   = 4;
    localparam int RES_W  = 10;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             start_set, start_clr, inj_req;
    logic [1:0]       mode_sel;
    logic [CH_W-1:0]  chan_sel, inj_chan;
    logic             clr_eoc, clr_eoi, clr_ccir, clr_injreq;
    logic             conv_done;
    logic [RES_W-1:0] conv_result;
    logic             conv_start;
    logic [CH_W-1:0]  conv_chan;
    logic [RES_W-1:0] std_result, inj_result;
    logic             std_busy, inj_flag, eoc_irq, eoi_irq, cc_irq;

    always #10 clk = ~clk;

    adc_seq_ctrl #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start_set(start_set), .start_clr(start_clr),
        .mode_sel(mode_sel), .chan_sel(chan_sel), .inj_req(inj_req),
        .inj_chan(inj_chan), .clr_eoc(clr_eoc), .clr_eoi(clr_eoi),
        .clr_ccir(clr_ccir), .clr_injreq(clr_injreq), .conv_done(conv_done),
        .conv_result(conv_result), .conv_start(conv_start),
        .conv_chan(conv_chan), .std_result(std_result),
        .inj_result(inj_result), .std_busy(std_busy), .inj_flag(inj_flag),
        .eoc_irq(eoc_irq), .eoi_irq(eoi_irq), .cc_irq(cc_irq)
    );

    int checks = 0;
    int fails  = 0;
    int mon_checks = 0;
    int mon_fails  = 0;

    function automatic logic [RES_W-1:0] res_of(input logic [CH_W-1:0] ch);
        return RES_W'((int'(ch) * 41 + 7) % 1024);
    endfunction

    // Converter model: answers each accepted start after lat_cfg cycles
    logic            cbusy;
    int              ccnt;
    int              lat_cfg = 4;
    logic [CH_W-1:0] cch;
    always @(posedge clk) begin
        if (!rst_n) begin
            cbusy       <= 1'b0;
            ccnt        <= 0;
            cch         <= '0;
            conv_done   <= 1'b0;
            conv_result <= '0;
        end else begin
            conv_done <= 1'b0;
            if (conv_start && !cbusy) begin
                cbusy <= 1'b1;
                ccnt  <= lat_cfg;
                cch   <= conv_chan;
            end else if (cbusy) begin
                if (ccnt == 1) begin
                    conv_done   <= 1'b1;
                    conv_result <= res_of(cch);
                    cbusy       <= 1'b0;
                end
                ccnt <= ccnt - 1;
            end
        end
    end

    // Start monitor: logs channels, flags a start during a busy converter
    logic [CH_W-1:0] start_log [64];
    int nstart = 0;
    always @(negedge clk) begin
        if (rst_n && conv_start) begin
            mon_checks++;
            if (cbusy) begin
                mon_fails++;
                $display("FAIL R8 start while converter busy: actual=1 expected=0");
            end
            start_log[nstart % 64] = conv_chan;
            nstart++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_idle();
        int idle = 0;
        int t = 0;
        while (idle < 3 && t < 3000) begin
            @(negedge clk);
            t++;
            if (!std_busy && !cbusy && !conv_start && !conv_done) idle++;
            else idle = 0;
        end
        if (t >= 3000) chk("R12 wait_idle timeout", 1, 0);
    endtask

    task automatic wait_done();
        int t = 0;
        while (!conv_done && t < 3000) begin
            @(negedge clk);
            t++;
        end
        if (t >= 3000) chk("R9 wait_done timeout", 1, 0);
    endtask

    task automatic clear_flags();
        clr_eoc = 1; clr_eoi = 1; clr_ccir = 1;
        tick(1);
        clr_eoc = 0; clr_eoi = 0; clr_ccir = 0;
    endtask

    task automatic do_start(input logic [1:0] m, input int ch);
        mode_sel = m; chan_sel = CH_W'(ch); start_set = 1;
        tick(1);
        start_set = 0;
    endtask

    task automatic do_inj(input int ch);
        inj_chan = CH_W'(ch); inj_req = 1;
        tick(1);
        inj_req = 0;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R12: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures",
                 checks + mon_checks + 1, fails + mon_fails);
        $finish;
    end

    initial begin
        int base;
        int seed;
        logic [RES_W-1:0] keep;
        seed = $urandom(32'd20240);
        rst_n = 0; start_set = 0; start_clr = 0; inj_req = 0;
        mode_sel = 0; chan_sel = 0; inj_chan = 0;
        clr_eoc = 0; clr_eoi = 0; clr_ccir = 0; clr_injreq = 0;
        tick(3);
        // R1: reset state
        chk("R1 conv_start", int'(conv_start), 0);
        chk("R1 flags", int'({std_busy, inj_flag, eoc_irq, eoi_irq, cc_irq}), 0);
        chk("R1 results", int'(std_result) + int'(inj_result), 0);
        rst_n = 1;
        tick(2);
        chk("R1 idle after reset", int'(conv_start | std_busy), 0);

        // R2: single conversion
        lat_cfg = 4;
        do_start(2'b00, 5);
        chk("R2 start issued", int'(conv_start), 1);
        chk("R2 channel", int'(conv_chan), 5);
        chk("R12 busy after start", int'(std_busy), 1);
        wait_idle();
        chk("R2 std_result", int'(std_result), int'(res_of(5)));
        chk("R2 eoc_irq", int'(eoc_irq), 1);
        chk("R2 busy cleared", int'(std_busy), 0);

        // R3 scan with R5 ignored restart
        clear_flags();
        base = nstart;
        do_start(2'b01, 3);
        tick(2);
        do_start(2'b00, 9);
        wait_idle();
        chk("R3 conversion count", nstart - base, 4);
        for (int k = 0; k < 4; k++)
            chk("R3 scan order", int'(start_log[(base + k) % 64]), 3 - k);
        chk("R5 ignored start channel", int'(start_log[base % 64]), 3);
        chk("R3 last result", int'(std_result), int'(res_of(0)));

        // R4 continuous single channel
        base = nstart;
        do_start(2'b10, 2);
        while (nstart - base < 3) tick(1);
        start_clr = 1; tick(1); start_clr = 0;
        wait_idle();
        chk("R4 stopped", int'(std_busy), 0);
        for (int k = 0; k < nstart - base; k++)
            chk("R4 repeat channel", int'(start_log[(base + k) % 64]), 2);

        // R4 continuous scan: passes of 1,0 finish whole
        base = nstart;
        do_start(2'b11, 1);
        while (nstart - base < 5) tick(1);
        start_clr = 1; tick(1); start_clr = 0;
        wait_idle();
        chk("R4 whole passes", (nstart - base) % 2, 0);
        chk("R4 pass order", int'(start_log[(base + 2) % 64]), 1);

        // R6 / R7 injection while idle
        clear_flags();
        keep = std_result;
        do_inj(11);
        chk("R6 inj_flag", int'(inj_flag), 1);
        chk("R6 cc_irq", int'(cc_irq), 1);
        chk("R8 inj issued", int'(conv_start), 1);
        chk("R8 inj channel", int'(conv_chan), 11);
        wait_idle();
        chk("R7 inj_result", int'(inj_result), int'(res_of(11)));
        chk("R7 eoi_irq", int'(eoi_irq), 1);
        chk("R7 inj_flag cleared", int'(inj_flag), 0);
        chk("R7 std_result untouched", int'(std_result), int'(keep));

        // R8 priority: both pending at once
        clear_flags();
        base = nstart;
        mode_sel = 2'b00; chan_sel = 4; inj_chan = 12;
        start_set = 1; inj_req = 1;
        tick(1);
        start_set = 0; inj_req = 0;
        chk("R8 injection first", int'(conv_chan), 12);
        wait_idle();
        chk("R8 then standard", int'(start_log[(base + 1) % 64]), 4);
        chk("R8 std_result", int'(std_result), int'(res_of(4)));

        // R11 set and clear in the same cycle
        clear_flags();
        do_inj(6);
        wait_done();
        clr_eoi = 1; tick(1); clr_eoi = 0;
        chk("R11 eoi set wins", int'(eoi_irq), 1);
        clr_eoi = 1; tick(1); clr_eoi = 0;
        chk("R11 eoi cleared", int'(eoi_irq), 0);
        inj_chan = 6; inj_req = 1; clr_ccir = 1;
        tick(1);
        inj_req = 0; clr_ccir = 0;
        chk("R11 cc set wins", int'(cc_irq), 1);
        wait_idle();

        // R9 start in the cycle the injected result is stored
        clear_flags();
        lat_cfg = 6;
        do_inj(13);
        wait_done();
        mode_sel = 2'b00; chan_sel = 6; start_set = 1;
        tick(1);
        start_set = 0;
        chk("R9 std issued after store", int'(conv_start), 1);
        chk("R9 std channel", int'(conv_chan), 6);
        chk("R9 eoi_irq", int'(eoi_irq), 1);
        chk("R9 inj_result", int'(inj_result), int'(res_of(13)));
        wait_idle();
        chk("R9 std_result", int'(std_result), int'(res_of(6)));

        // R9 start one cycle before the done pulse
        clear_flags();
        do_inj(1);
        while (!(cbusy && ccnt == 1)) tick(1);
        mode_sel = 2'b00; chan_sel = 7; start_set = 1;
        tick(1);
        start_set = 0;
        chk("R9 no abort, done arrives", int'(conv_done), 1);
        chk("R9 no early start", int'(conv_start), 0);
        tick(1);
        chk("R9 deferred start", int'(conv_start), 1);
        chk("R9 deferred channel", int'(conv_chan), 7);
        chk("R9 inj stored", int'(inj_result), int'(res_of(1)));
        wait_idle();
        do_inj(14);
        wait_idle();
        chk("R9 later injection served", int'(inj_result), int'(res_of(14)));

        // R10 clearing the visible flag before the injection is issued
        clear_flags();
        do_start(2'b00, 3);
        tick(1);
        do_inj(10);
        clr_injreq = 1; tick(1); clr_injreq = 0;
        chk("R10 visible flag cleared", int'(inj_flag), 0);
        wait_idle();
        chk("R10 inj_result", int'(inj_result), int'(res_of(10)));
        chk("R10 eoi_irq", int'(eoi_irq), 1);

        // Random phase: standard work with one injection at a random offset
        for (int it = 0; it < 40; it++) begin
            int m;
            int ch;
            int ic;
            int off;
            m   = int'($urandom % 2);
            ch  = int'($urandom % 8);
            ic  = 8 + int'($urandom % 8);
            off = int'($urandom % 14);
            lat_cfg = 1 + int'($urandom % 6);
            clear_flags();
            base = nstart;
            do_start(2'(m), ch);
            tick(off);
            do_inj(ic);
            wait_idle();
            chk("R9 random std_result", int'(std_result),
                int'(res_of(CH_W'((m == 1) ? 0 : ch))));
            chk("R7 random inj_result", int'(inj_result), int'(res_of(CH_W'(ic))));
            chk("R7 random eoi", int'(eoi_irq), 1);
            chk("R3 random count", nstart - base, ((m == 1) ? ch + 1 : 1) + 1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures",
                 checks + mon_checks, fails + mon_fails);
        $finish;
    end
endmodule